// File: doc/BRIEF.md
# USB IN Endpoint Control and Handshake Selector

This block keeps the control state of one USB device IN endpoint and chooses the handshake the endpoint returns to each token. Software reaches it through a flat register port with a write strobe and a read-back word. Through that port software can enable the endpoint, ask for it to be disabled, force the data PID or frame parity, set or clear a NAK flag, and program a max-packet-size code. The protocol engine reports three completion events: SETUP stage done, endpoint disabled and transfer complete. Each of these events clears the control bits. One cycle after the clear, the block raises a matching one-cycle interrupt pulse.

For every token, the block gives a response code to the packet engine in the cycle after the token. The code asks for data, an ACK or a NAK. A SETUP token always gets an ACK. Other tokens get a NAK while the NAK flag is set, while the FIFO has nothing ready, or while the endpoint is not enabled.

Register word (bit: meaning): 0 enable, write 1 to set. 1 disable request, write 1 to set. 2 set NAK, write only. 3 clear NAK, write only. 4 force DATA1 or odd parity, write only. 5 force DATA0 or even parity, write only. 6 NAK flag, read only. 7 PID or parity state, read only, where 1 means DATA1 or odd. 8 active indicator, read only. 10:9 max-packet code, read/write. All other bits are reserved. Endpoint type codes on `ep_type`: 00 control, 01 isochronous, 10 bulk, 11 interrupt. Response codes on `hs_resp`: 00 none, 01 data, 10 ACK, 11 NAK.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset, every control bit, the NAK flag, the PID/parity state and the max-packet code read 0. `hs_resp` is 00 and all three interrupt outputs are low.
- R2: Writing 1 to bit 0 sets the enable bit, and writing 0 there leaves it unchanged. Any of the three events clears it at the next edge. An event wins over a same-cycle enable write.
- R3: Writing 1 to bit 1 sets the disable bit only while enable is 1. Otherwise the write is ignored. Any of the three events clears the disable bit together with enable.
- R4: Each event produces a one-cycle pulse on its own interrupt output. The pulse comes one cycle after the edge that clears the control bits, which is the second edge after the event is sampled.
- R5: Writing 1 to bit 2 sets the NAK flag and writing 1 to bit 3 clears it. If both are written in the same cycle, the flag is set.
- R6: The cycle after a non-SETUP token, `hs_resp` is NAK (11) if the NAK flag is 1, if `fifo_ready` is 0 or if enable is 0. Otherwise it is data (01). The response uses the state from before that edge. With no token, `hs_resp` is 00.
- R7: The cycle after a SETUP token, `hs_resp` is ACK (10), whatever the NAK flag and the enable bit hold.
- R8: On control, bulk and interrupt types, writing bit 4 forces the state bit to 1 (DATA1) and writing bit 5 forces it to 0 (DATA0). A pulse on `txn_ok` toggles the state bit. A same-cycle force wins over the toggle.
- R9: On the isochronous type, bits 4 and 5 force the state bit to odd (1) or even (0). On this type, `txn_ok` leaves the bit unchanged.
- R10: Bits 10:9 hold the code written to them. `mps_bytes` decodes the code as 00→64, 01→32, 10→16 and 11→8. Bit 8 reads 1 exactly when `ep_type` is control.
- R11: Reserved bits read 0 and ignore writes. The write-only bits 2–5 read 0. Writes to bits 6–8 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read-back word |
| ep_type | input | 2 | Endpoint type code |
| evt_setup_done | input | 1 | SETUP stage done event |
| evt_ep_disabled | input | 1 | Endpoint disabled event |
| evt_xfer_done | input | 1 | Transfer complete event |
| tok_valid | input | 1 | A token is addressed to this endpoint |
| tok_setup | input | 1 | The token is a SETUP |
| fifo_ready | input | 1 | Transmit FIFO holds data for the endpoint |
| txn_ok | input | 1 | A data transaction completed successfully |
| hs_resp | output | 2 | Response code to the packet engine |
| irq_setup_done | output | 1 | SETUP done interrupt pulse |
| irq_ep_disabled | output | 1 | Endpoint disabled interrupt pulse |
| irq_xfer_done | output | 1 | Transfer complete interrupt pulse |
| mps_bytes | output | 7 | Decoded maximum packet size in bytes |

## Verification
On every cycle, the bound checker checks these relations:
- An event clears enable.
- The disable bit never stands without enable.
- Each interrupt follows its event by exactly two edges.
- A set-NAK write always leaves the flag set.
- SETUP tokens get an ACK and NAK-flagged tokens get a NAK.
- Idle cycles give no response.
- Reserved bits stay zero.

Only the bench scenarios show the rest: the PID and parity forcing against toggling on each endpoint type, the max-packet decode, the ignored disable request on an idle endpoint, and the outcome of an enable write that meets an event in the same cycle.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

   typedef enum logic [1:0] {
      HS_NONE = 2'b00,
      HS_DATA = 2'b01,
      HS_ACK  = 2'b10,
      HS_NAK  = 2'b11
   } hs_e;

   typedef enum logic [1:0] {
      EPK_CTRL = 2'b00,
      EPK_ISO  = 2'b01,
      EPK_BULK = 2'b10,
      EPK_INTR = 2'b11
   } ep_kind_e;

   localparam int unsigned BIT_EN     = 0;
   localparam int unsigned BIT_DIS    = 1;
   localparam int unsigned BIT_NAKSET = 2;
   localparam int unsigned BIT_NAKCLR = 3;
   localparam int unsigned BIT_FORCE1 = 4;
   localparam int unsigned BIT_FORCE0 = 5;
   localparam int unsigned BIT_NAK    = 6;
   localparam int unsigned BIT_PHASE  = 7;
   localparam int unsigned BIT_ACTIVE = 8;
   localparam int unsigned MPS_LSB    = 9;
   localparam int unsigned MPS_W      = 2;
   localparam int unsigned MIN_REG_W  = MPS_LSB + MPS_W;
   localparam int unsigned N_EVT      = 3;

endpackage

// File: rtl/usb_ep_state.sv
module usb_ep_state
   import usb_ep_pkg::*;
#(
   parameter int unsigned MW = MPS_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_dis,
   input  logic          wr_nakset,
   input  logic          wr_nakclr,
   input  logic          wr_force1,
   input  logic          wr_force0,
   input  logic          wr_mps,
   input  logic [MW-1:0] mps_in,
   input  ep_kind_e      kind,
   input  logic          evt_any,
   input  logic          txn_ok,
   output logic          en,
   output logic          dis,
   output logic          nak,
   output logic          phase,
   output logic [MW-1:0] mps
);

   logic en_d, dis_d, nak_d, phase_d;
   logic toggles;

   assign toggles = (kind != EPK_ISO);

   always_comb begin
      en_d = en;
      if (evt_any)     en_d = 1'b0;
      else if (wr_en)  en_d = 1'b1;

      dis_d = dis;
      if (evt_any)             dis_d = 1'b0;
      else if (wr_dis && en)   dis_d = 1'b1;

      nak_d = nak;
      if (wr_nakset)      nak_d = 1'b1;
      else if (wr_nakclr) nak_d = 1'b0;

      phase_d = phase;
      if (wr_force1)                 phase_d = 1'b1;
      else if (wr_force0)            phase_d = 1'b0;
      else if (txn_ok && toggles)    phase_d = ~phase;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en    <= 1'b0;
         dis   <= 1'b0;
         nak   <= 1'b0;
         phase <= 1'b0;
         mps   <= '0;
      end else begin
         en    <= en_d;
         dis   <= dis_d;
         nak   <= nak_d;
         phase <= phase_d;
         if (wr_mps) mps <= mps_in;
      end
   end

endmodule

// File: rtl/usb_ep_irq.sv
module usb_ep_irq #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   output logic [N-1:0] irq
);

   for (genvar g = 0; g < N; g++) begin : g_ch
      logic stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q <= 1'b0;
            irq[g]  <= 1'b0;
         end else begin
            stage_q <= evt[g];
            irq[g]  <= stage_q;
         end
      end
   end

endmodule

// File: rtl/usb_ep_hs.sv
module usb_ep_hs
   import usb_ep_pkg::*;
#(
   parameter bit RESP_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tok_valid,
   input  logic tok_setup,
   input  logic fifo_ready,
   input  logic en,
   input  logic nak,
   output hs_e  resp
);

   hs_e pick;

   always_comb begin
      pick = HS_NONE;
      if (tok_valid) begin
         if (tok_setup)                    pick = HS_ACK;
         else if (nak || !fifo_ready || !en) pick = HS_NAK;
         else                              pick = HS_DATA;
      end
   end

   if (RESP_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) resp <= HS_NONE;
         else        resp <= pick;
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign resp = pick;
   end

endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
   import usb_ep_pkg::*;
#(
   parameter int unsigned REG_W    = 16,
   parameter bit          RESP_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic [1:0]       ep_type,
   input  logic             evt_setup_done,
   input  logic             evt_ep_disabled,
   input  logic             evt_xfer_done,
   input  logic             tok_valid,
   input  logic             tok_setup,
   input  logic             fifo_ready,
   input  logic             txn_ok,
   output logic [1:0]       hs_resp,
   output logic             irq_setup_done,
   output logic             irq_ep_disabled,
   output logic             irq_xfer_done,
   output logic [6:0]       mps_bytes
);

   if (REG_W < MIN_REG_W) begin : g_bad_width
      $error("usb_in_ep_ctrl: REG_W too small for the register layout");
   end

   ep_kind_e         kind;
   logic [N_EVT-1:0] evt_vec, irq_vec;
   logic             en, dis, nak, phase;
   logic [MPS_W-1:0] mps;
   hs_e              resp;

   assign kind    = ep_kind_e'(ep_type);
   assign evt_vec = {evt_xfer_done, evt_ep_disabled, evt_setup_done};

   usb_ep_state #(.MW(MPS_W)) state_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_we && reg_wdata[BIT_EN]),
      .wr_dis    (reg_we && reg_wdata[BIT_DIS]),
      .wr_nakset (reg_we && reg_wdata[BIT_NAKSET]),
      .wr_nakclr (reg_we && reg_wdata[BIT_NAKCLR]),
      .wr_force1 (reg_we && reg_wdata[BIT_FORCE1]),
      .wr_force0 (reg_we && reg_wdata[BIT_FORCE0]),
      .wr_mps    (reg_we),
      .mps_in    (reg_wdata[MPS_LSB +: MPS_W]),
      .kind      (kind),
      .evt_any   (|evt_vec),
      .txn_ok    (txn_ok),
      .en        (en),
      .dis       (dis),
      .nak       (nak),
      .phase     (phase),
      .mps       (mps)
   );

   usb_ep_irq #(.N(N_EVT)) irq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt_vec),
      .irq   (irq_vec)
   );

   usb_ep_hs #(.RESP_REG(RESP_REG)) hs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tok_valid  (tok_valid),
      .tok_setup  (tok_setup),
      .fifo_ready (fifo_ready),
      .en         (en),
      .nak        (nak),
      .resp       (resp)
   );

   always_comb begin
      reg_rdata                       = '0;
      reg_rdata[BIT_EN]               = en;
      reg_rdata[BIT_DIS]              = dis;
      reg_rdata[BIT_NAK]              = nak;
      reg_rdata[BIT_PHASE]            = phase;
      reg_rdata[BIT_ACTIVE]           = (kind == EPK_CTRL);
      reg_rdata[MPS_LSB +: MPS_W]     = mps;
   end

   assign hs_resp         = resp;
   assign irq_setup_done  = irq_vec[0];
   assign irq_ep_disabled = irq_vec[1];
   assign irq_xfer_done   = irq_vec[2];
   assign mps_bytes       = 7'd64 >> mps;

   logic unused_ro;
   assign unused_ro = ^reg_wdata[BIT_ACTIVE:BIT_NAK];
   if (REG_W > MIN_REG_W) begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = ^reg_wdata[REG_W-1:MIN_REG_W];
   end

endmodule

// File: rtl/usb_in_ep_ctrl_chk.sv
module usb_in_ep_ctrl_chk #(
   parameter int unsigned REG_W    = 16,
   parameter bit          RESP_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic             wr_nakset,
   input logic [REG_W-1:0] reg_rdata,
   input logic             evt_setup_done,
   input logic             evt_ep_disabled,
   input logic             evt_xfer_done,
   input logic             tok_valid,
   input logic             tok_setup,
   input logic [1:0]       hs_resp,
   input logic             irq_setup_done,
   input logic             irq_ep_disabled,
   input logic             irq_xfer_done
);

   // R2: any completion event leaves enable cleared
   p_evt_clears_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_setup_done || evt_ep_disabled || evt_xfer_done) |=> !reg_rdata[0]);

   // R3: disable never stands without enable
   p_dis_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[1] |-> reg_rdata[0]);

   // R4: each interrupt follows its event by two edges
   p_irq_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_setup_done == $past(evt_setup_done, 2));
   p_irq_dis_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ep_disabled == $past(evt_ep_disabled, 2));
   p_irq_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_xfer_done == $past(evt_xfer_done, 2));

   // R5: set-NAK write always leaves the flag set
   p_nak_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && wr_nakset) |=> reg_rdata[6]);

   // R11: reserved bits stay zero
   p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[REG_W-1:11] == '0);

   if (RESP_REG) begin : g_reg
      // R7: SETUP is always acknowledged
      p_setup_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (tok_valid && tok_setup) |=> hs_resp == 2'b10);
      // R6: NAK flag forces NAK on data tokens
      p_nak_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (tok_valid && !tok_setup && reg_rdata[6]) |=> hs_resp == 2'b11);
      // R6: no token, no response
      p_idle_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !tok_valid |=> hs_resp == 2'b00);
   end else begin : g_comb
      p_setup_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (tok_valid && tok_setup) |-> hs_resp == 2'b10);
      p_nak_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (tok_valid && !tok_setup && reg_rdata[6]) |-> hs_resp == 2'b11);
      p_idle_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !tok_valid |-> hs_resp == 2'b00);
   end

endmodule

bind usb_in_ep_ctrl usb_in_ep_ctrl_chk #(.REG_W(REG_W), .RESP_REG(RESP_REG)) chk_i (
   .clk             (clk),
   .rst_n           (rst_n),
   .reg_we          (reg_we),
   .wr_nakset       (reg_wdata[2]),
   .reg_rdata       (reg_rdata),
   .evt_setup_done  (evt_setup_done),
   .evt_ep_disabled (evt_ep_disabled),
   .evt_xfer_done   (evt_xfer_done),
   .tok_valid       (tok_valid),
   .tok_setup       (tok_setup),
   .hs_resp         (hs_resp),
   .irq_setup_done  (irq_setup_done),
   .irq_ep_disabled (irq_ep_disabled),
   .irq_xfer_done   (irq_xfer_done)
);

// File: tb/usb_in_ep_ctrl_tb_top.sv
module usb_in_ep_ctrl_tb_top;

   localparam int unsigned REG_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_we = 1'b0;
   logic [REG_W-1:0] reg_wdata = '0;
   logic [REG_W-1:0] reg_rdata;
   logic [1:0]       ep_type = 2'd2;
   logic             evt_setup_done = 1'b0, evt_ep_disabled = 1'b0, evt_xfer_done = 1'b0;
   logic             tok_valid = 1'b0, tok_setup = 1'b0, fifo_ready = 1'b0, txn_ok = 1'b0;
   logic [1:0]       hs_resp;
   logic             irq_setup_done, irq_ep_disabled, irq_xfer_done;
   logic [6:0]       mps_bytes;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   usb_in_ep_ctrl #(.REG_W(REG_W), .RESP_REG(1'b1)) dut_i (
      .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata), .ep_type (ep_type),
      .evt_setup_done (evt_setup_done), .evt_ep_disabled (evt_ep_disabled),
      .evt_xfer_done (evt_xfer_done), .tok_valid (tok_valid), .tok_setup (tok_setup),
      .fifo_ready (fifo_ready), .txn_ok (txn_ok), .hs_resp (hs_resp),
      .irq_setup_done (irq_setup_done), .irq_ep_disabled (irq_ep_disabled),
      .irq_xfer_done (irq_xfer_done), .mps_bytes (mps_bytes)
   );

   typedef struct packed {
      logic        we;
      logic [15:0] wdata;
      logic [1:0]  typ;
      logic        tv, ts, fr, txn;
      logic [15:0] exp_rd;
      logic [1:0]  exp_hs;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t TBL [NV] = '{
      '{1'b1, 16'h0001, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0001, 2'd0}, // R2 enable
      '{1'b0, 16'h0000, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0001, 2'd1}, // R6 data
      '{1'b1, 16'h0004, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0041, 2'd1}, // R5 set, R6 old state
      '{1'b0, 16'h0000, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0041, 2'd3}, // R6 NAK flag
      '{1'b0, 16'h0000, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0041, 2'd2}, // R7 setup ack
      '{1'b1, 16'h000C, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0041, 2'd0}, // R5 set wins
      '{1'b1, 16'h0008, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0001, 2'd0}, // R5 clear
      '{1'b0, 16'h0000, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0001, 2'd3}, // R6 fifo empty
      '{1'b0, 16'h0000, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0081, 2'd0}, // R8 toggle
      '{1'b1, 16'h0020, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0001, 2'd0}, // R8 force beats toggle
      '{1'b1, 16'h0010, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0081, 2'd0}, // R8 force DATA1
      '{1'b1, 16'h0600, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0681, 2'd0}, // R10 mps code
      '{1'b1, 16'hFFC0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0681, 2'd0}, // R11 reserved
      '{1'b1, 16'h0620, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0601, 2'd0}, // R9 even
      '{1'b0, 16'h0000, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0601, 2'd0}, // R9 no toggle
      '{1'b1, 16'h0610, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0681, 2'd0}, // R9 odd
      '{1'b0, 16'h0000, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0681, 2'd1}, // R6 iso data
      '{1'b0, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0781, 2'd0}  // R10 active on control
   };

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle();
      reg_we = 1'b0; reg_wdata = '0;
      evt_setup_done = 1'b0; evt_ep_disabled = 1'b0; evt_xfer_done = 1'b0;
      tok_valid = 1'b0; tok_setup = 1'b0; fifo_ready = 1'b0; txn_ok = 1'b0;
   endtask

   task automatic irqs(input string req, input logic [2:0] exp);
      chk(req, {29'd0, irq_xfer_done, irq_ep_disabled, irq_setup_done}, {29'd0, exp});
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      chk("R1 rdata", reg_rdata, 0);
      chk("R1 resp", hs_resp, 0);
      irqs("R1 irq", 3'b000);
      chk("R1 mps", mps_bytes, 64);
      rst_n = 1'b1;
      step();

      for (int i = 0; i < NV; i++) begin
         reg_we = TBL[i].we; reg_wdata = TBL[i].wdata; ep_type = TBL[i].typ;
         tok_valid = TBL[i].tv; tok_setup = TBL[i].ts;
         fifo_ready = TBL[i].fr; txn_ok = TBL[i].txn;
         step();
         chk($sformatf("row%0d rdata", i), reg_rdata, TBL[i].exp_rd);
         chk($sformatf("row%0d resp", i), hs_resp, TBL[i].exp_hs);
      end
      idle();
      ep_type = 2'd0;
      step();

      // R10 decode
      chk("R10 mps 11", mps_bytes, 8);
      reg_we = 1'b1; reg_wdata = 16'h0200;
      step(); idle();
      chk("R10 mps 01", mps_bytes, 32);
      chk("R10 rdata", reg_rdata, 16'h0381);
      reg_we = 1'b1; reg_wdata = 16'h0400;
      step(); idle();
      chk("R10 mps 10", mps_bytes, 16);
      reg_we = 1'b1; reg_wdata = 16'h0200;
      step(); idle();

      // R3 disable while enabled
      reg_we = 1'b1; reg_wdata = 16'h0202;
      step(); idle();
      chk("R3 dis set", reg_rdata, 16'h0383);

      // R2/R3/R4 disabled event
      evt_ep_disabled = 1'b1;
      step(); idle();
      chk("R2 R3 cleared", reg_rdata, 16'h0380);
      irqs("R4 not yet", 3'b000);
      step();
      irqs("R4 pulse dis", 3'b010);
      step();
      irqs("R4 pulse ends", 3'b000);

      // R3 disable ignored while idle
      reg_we = 1'b1; reg_wdata = 16'h0202;
      step(); idle();
      chk("R3 ignored", reg_rdata, 16'h0380);

      // R2 event beats same-cycle enable write
      reg_we = 1'b1; reg_wdata = 16'h0201; evt_xfer_done = 1'b1;
      step(); idle();
      chk("R2 event wins", reg_rdata, 16'h0380);
      step();
      irqs("R4 pulse xfer", 3'b100);

      // R4 setup done
      reg_we = 1'b1; reg_wdata = 16'h0201;
      step(); idle();
      chk("R2 re-enable", reg_rdata, 16'h0381);
      evt_setup_done = 1'b1;
      step(); idle();
      chk("R2 setup clears", reg_rdata, 16'h0380);
      step();
      irqs("R4 pulse setup", 3'b001);

      // R7 ack while disabled, R6 NAK while disabled
      tok_valid = 1'b1; tok_setup = 1'b1;
      step(); idle();
      chk("R7 ack disabled", hs_resp, 2'd2);
      tok_valid = 1'b1; fifo_ready = 1'b1;
      step(); idle();
      chk("R6 nak disabled", hs_resp, 2'd3);
      step();
      chk("R6 idle none", hs_resp, 2'd0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule